// File: doc/BRIEF.md
# DMA Handshake Controller with Selectable End-of-Transfer

This block moves 16-bit words between an external processor's DMA engine and a small internal word buffer. Once armed through its configuration register, it raises a request line. The processor answers with an active-low acknowledge and pulses an active-low strobe for each word. In one direction the processor writes data into the buffer. In the other it reads data out of the buffer. The buffer pointer starts at zero on every arm and advances by one word for each accepted strobe.

The request can behave in two ways. In single-cycle mode it drops after every word. In burst mode it stays high for a fixed group of words. The transfer can end in two ways. An external end-of-transfer input can stop it. An internal byte counter can also stop it, when the counter reaches a programmed transfer count. When the transfer ends, the request falls, a done flag rises, and later strobes are ignored until the controller is armed again. The buffer depth must be a power of two, and the pointer wraps at the top.

Top module: `dmah_ctrl`

## Requirements
- R1: After reset the request and done outputs are low, and both registers read back as zero.
- R2: A write to address 0xA1 loads the configuration register and a write to 0xA2 loads the 16-bit transfer count. A read address of 0x21 returns the configuration and 0x22 returns the count. Any other read address returns zero. Configuration bits: bit 0 is enable, bit 1 is direction (1 = processor writes into the buffer with the write strobe, 0 = processor reads with the read strobe), bit 2 selects the internal counter as the end source, and bit 3 selects burst mode. Only bits 3:0 are stored.
- R3: A configuration write with bit 0 set arms the controller. It clears the byte counter, the buffer pointer and done, and the request is high from the next clock edge. A configuration write with bit 0 clear drops the request at the next edge.
- R4: One word moves per strobe. A word moves when the strobe for the current direction is sampled low after being high in the previous cycle, while the acknowledge is low and the request is high. The strobe for the other direction has no effect.
- R5: In write direction the input data is stored at the pointer. In read direction the data output shows the buffer word at the pointer. The pointer increments after each word.
- R6: In single-cycle mode the request is low from the edge after each word. It returns high at the edge after the acknowledge is sampled high.
- R7: In burst mode the request stays high for 4 words and then drops. It returns in the same way as in R6.
- R8: The byte counter adds 2 per word. With bit 2 set, when the count after a word equals the transfer count, the request falls and done rises at the next edge. In this mode the external end input is ignored.
- R9: With bit 2 clear, an external end input that is high while the controller is armed and not done drops the request and sets done at the next edge. In this mode a counter match has no effect.
- R10: Once done is set, strobes move no data and the pointer stays put until the next arm.
- R11: A strobe in the same cycle as the external end input still moves its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write enable |
| reg_waddr | input | 8 | Register write address |
| reg_wdata | input | 16 | Register write data |
| reg_raddr | input | 8 | Register read address |
| reg_rdata | output | 16 | Register read data |
| dreq | output | 1 | DMA request |
| dack_n | input | 1 | DMA acknowledge, active low |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| eot_ext | input | 1 | External end-of-transfer, active high |
| din | input | 16 | Data from the processor |
| dout | output | 16 | Buffer word at the pointer |
| done | output | 1 | Transfer finished |

## Verification
The assertions take the strobes, acknowledge and end input to be synchronous to the clock. They also take it that a configuration write does not land in the same cycle as a strobe edge, and that configuration is not changed while a transfer runs. The stimulus drives every input on the falling clock edge. It holds each strobe low for exactly one cycle, and it changes the configuration only when no strobe is active. Acknowledge is released between groups of words, so the return of the request after each gap can be observed.

// File: rtl/dmah_pkg.sv
package dmah_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2,
        ST_DONE = 2'd3
    } dma_st_e;

    localparam logic [7:0] CFG_WR_ADDR = 8'hA1;
    localparam logic [7:0] TC_WR_ADDR  = 8'hA2;
    localparam logic [7:0] CFG_RD_ADDR = 8'h21;
    localparam logic [7:0] TC_RD_ADDR  = 8'h22;

    localparam int CFG_W     = 4;
    localparam int CFG_EN    = 0;
    localparam int CFG_DIR   = 1;
    localparam int CFG_CSEL  = 2;
    localparam int CFG_BURST = 3;

endpackage

// File: rtl/dmah_regs.sv
module dmah_regs
    import dmah_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [AW-1:0]     reg_waddr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    input  logic [AW-1:0]     reg_raddr_i,
    output logic [DW-1:0]     reg_rdata_o,
    output logic [CFG_W-1:0]  cfg_o,
    output logic [DW-1:0]     tcount_o,
    output logic              arm_o,
    output logic              disarm_o
);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [DW-1:0]    tc;
    } regs_t;

    regs_t r_d, r_q;
    logic  cfg_hit;
    logic  tc_hit;

    always_comb begin
        r_d     = r_q;
        cfg_hit = reg_wr_i && (reg_waddr_i == AW'(CFG_WR_ADDR));
        tc_hit  = reg_wr_i && (reg_waddr_i == AW'(TC_WR_ADDR));
        if (cfg_hit) r_d.cfg = reg_wdata_i[CFG_W-1:0];
        if (tc_hit)  r_d.tc  = reg_wdata_i;
        arm_o    = cfg_hit && reg_wdata_i[CFG_EN];
        disarm_o = cfg_hit && !reg_wdata_i[CFG_EN];
        if (reg_raddr_i == AW'(CFG_RD_ADDR))
            reg_rdata_o = DW'(r_q.cfg);
        else if (reg_raddr_i == AW'(TC_RD_ADDR))
            reg_rdata_o = r_q.tc;
        else
            reg_rdata_o = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_o    = r_q.cfg;
    assign tcount_o = r_q.tc;

    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_waddr_i == AW'(CFG_WR_ADDR))
        |=> (cfg_o == $past(reg_wdata_i[CFG_W-1:0])));

endmodule

// File: rtl/dmah_buf.sv
module dmah_buf #(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [PW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[addr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/dmah_seq.sv
module dmah_seq
    import dmah_pkg::*;
#(
    parameter int DW        = 16,
    parameter int DEPTH     = 64,
    parameter int BURST_LEN = 4,
    localparam int PW       = $clog2(DEPTH),
    localparam int BW       = $clog2(BURST_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [DW-1:0]    tcount_i,
    input  logic             arm_i,
    input  logic             disarm_i,
    input  logic             dack_n_i,
    input  logic             rd_n_i,
    input  logic             wr_n_i,
    input  logic             eot_ext_i,
    output logic             dreq_o,
    output logic             done_o,
    output logic             buf_we_o,
    output logic [PW-1:0]    ptr_o
);

    typedef struct packed {
        dma_st_e       st;
        logic [DW-1:0] byte_cnt;
        logic [PW-1:0] ptr;
        logic [BW-1:0] bcnt;
        logic          done;
        logic          strb_prev;
    } seq_t;

    seq_t          s_d, s_q;
    logic          strb_now;
    logic          move;
    logic          active;
    logic          int_eot;
    logic          ext_eot;
    logic [DW-1:0] cnt_nx;
    logic [BW-1:0] bcnt_nx;
    logic [BW-1:0] blen;

    always_comb begin
        s_d         = s_q;
        strb_now    = cfg_i[CFG_DIR] ? !wr_n_i : !rd_n_i;
        s_d.strb_prev = strb_now;
        active      = (s_q.st == ST_REQ) || (s_q.st == ST_GAP);
        move        = (s_q.st == ST_REQ) && !dack_n_i && strb_now
                      && !s_q.strb_prev && !arm_i && !disarm_i;
        cnt_nx      = s_q.byte_cnt + DW'(2);
        bcnt_nx     = s_q.bcnt + BW'(1);
        blen        = cfg_i[CFG_BURST] ? BW'(BURST_LEN) : BW'(1);
        int_eot     = move && cfg_i[CFG_CSEL] && (cnt_nx == tcount_i);
        ext_eot     = !cfg_i[CFG_CSEL] && eot_ext_i;

        if (arm_i) begin
            s_d.st       = ST_REQ;
            s_d.byte_cnt = '0;
            s_d.ptr      = '0;
            s_d.bcnt     = '0;
            s_d.done     = 1'b0;
        end else if (disarm_i) begin
            s_d.st = ST_IDLE;
        end else if (active) begin
            if (move) begin
                s_d.ptr      = s_q.ptr + PW'(1);
                s_d.byte_cnt = cnt_nx;
                if (bcnt_nx == blen) begin
                    s_d.bcnt = '0;
                    s_d.st   = ST_GAP;
                end else begin
                    s_d.bcnt = bcnt_nx;
                end
            end
            if (int_eot || ext_eot) begin
                s_d.st   = ST_DONE;
                s_d.done = 1'b1;
            end else if ((s_q.st == ST_GAP) && dack_n_i) begin
                s_d.st = ST_REQ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.st        <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign dreq_o   = (s_q.st == ST_REQ);
    assign done_o   = s_q.done;
    assign buf_we_o = move && cfg_i[CFG_DIR];
    assign ptr_o    = s_q.ptr;

    p_arm_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (dreq_o && !done_o && ptr_o == '0));

    p_disarm_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_i |=> !dreq_o);

    p_single_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (move && !cfg_i[CFG_BURST]) |=> !dreq_o);

    p_burst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (move && cfg_i[CFG_BURST] && !int_eot && !ext_eot
         && (s_q.bcnt != BW'(BURST_LEN - 1))) |=> dreq_o);

    p_int_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (move && cfg_i[CFG_CSEL] && (s_q.byte_cnt + DW'(2) == tcount_i))
        |=> (done_o && !dreq_o));

    p_ext_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_o && !cfg_i[CFG_CSEL] && eot_ext_i && !arm_i && !disarm_i)
        |=> (done_o && !dreq_o));

    p_done_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !arm_i) |=> (done_o && $stable(ptr_o) && !$past(buf_we_o)));

endmodule

// File: rtl/dmah_ctrl.sv
module dmah_ctrl
    import dmah_pkg::*;
#(
    parameter int DW        = 16,
    parameter int DEPTH     = 64,
    parameter int BURST_LEN = 4,
    parameter int RAW       = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_waddr,
    input  logic [DW-1:0]  reg_wdata,
    input  logic [RAW-1:0] reg_raddr,
    output logic [DW-1:0]  reg_rdata,
    output logic           dreq,
    input  logic           dack_n,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic           eot_ext,
    input  logic [DW-1:0]  din,
    output logic [DW-1:0]  dout,
    output logic           done
);

    localparam int PW = $clog2(DEPTH);

    logic [CFG_W-1:0] cfg;
    logic [DW-1:0]    tcount;
    logic             arm;
    logic             disarm;
    logic             buf_we;
    logic [PW-1:0]    ptr;

    dmah_regs #(.AW(RAW), .DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_waddr_i (reg_waddr),
        .reg_wdata_i (reg_wdata),
        .reg_raddr_i (reg_raddr),
        .reg_rdata_o (reg_rdata),
        .cfg_o       (cfg),
        .tcount_o    (tcount),
        .arm_o       (arm),
        .disarm_o    (disarm)
    );

    dmah_seq #(.DW(DW), .DEPTH(DEPTH), .BURST_LEN(BURST_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i     (cfg),
        .tcount_i  (tcount),
        .arm_i     (arm),
        .disarm_i  (disarm),
        .dack_n_i  (dack_n),
        .rd_n_i    (rd_n),
        .wr_n_i    (wr_n),
        .eot_ext_i (eot_ext),
        .dreq_o    (dreq),
        .done_o    (done),
        .buf_we_o  (buf_we),
        .ptr_o     (ptr)
    );

    dmah_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .we_i    (buf_we),
        .addr_i  (ptr),
        .wdata_i (din),
        .rdata_o (dout)
    );

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!dreq && !done));

endmodule

// File: tb/tb_dmah_ctrl.sv
module tb_dmah_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_waddr = 8'h00;
    logic [15:0] reg_wdata = 16'h0;
    logic [7:0]  reg_raddr = 8'h21;
    logic [15:0] reg_rdata;
    logic        dreq;
    logic        dack_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        eot_ext = 1'b0;
    logic [15:0] din = 16'h0;
    logic [15:0] dout;
    logic        done;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    run = 1'b0;
    string cur_req = "R1";

    // behavioural reference model state
    int          m_state;
    int          m_ptr;
    int          m_cnt;
    int          m_bcnt;
    bit          m_done;
    bit          m_prev;
    logic [3:0]  m_cfg;
    logic [15:0] m_tc;
    logic [15:0] m_mem [64];
    bit          m_val [64];

    always #2.5 clk = ~clk;

    dmah_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .dreq(dreq), .dack_n(dack_n), .rd_n(rd_n), .wr_n(wr_n),
        .eot_ext(eot_ext), .din(din), .dout(dout), .done(done)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin : model
        bit strb, xfer, eot;
        int old, blen;
        if (!rst_n) begin
            m_state = 0; m_ptr = 0; m_cnt = 0; m_bcnt = 0;
            m_done = 0; m_prev = 0; m_cfg = '0; m_tc = '0;
            for (int i = 0; i < 64; i++) m_val[i] = 0;
        end else begin
            strb = m_cfg[1] ? !wr_n : !rd_n;
            xfer = (m_state == 1) && !dack_n && strb && !m_prev;
            old  = m_state;
            m_prev = strb;
            blen = m_cfg[3] ? 4 : 1;
            if (reg_wr && reg_waddr == 8'hA1) begin
                m_cfg = reg_wdata[3:0];
                if (reg_wdata[0]) begin
                    m_state = 1; m_cnt = 0; m_ptr = 0; m_bcnt = 0; m_done = 0;
                end else begin
                    m_state = 0;
                end
            end else if (old == 1 || old == 2) begin
                eot = 0;
                if (xfer) begin
                    if (m_cfg[1]) begin
                        m_mem[m_ptr] = din;
                        m_val[m_ptr] = 1;
                    end
                    m_ptr = (m_ptr + 1) % 64;
                    m_cnt = (m_cnt + 2) & 16'hFFFF;
                    m_bcnt++;
                    if (m_bcnt == blen) begin
                        m_bcnt = 0;
                        m_state = 2;
                    end
                    if (m_cfg[2] && m_cnt == int'(m_tc)) eot = 1;
                end
                if (!m_cfg[2] && eot_ext) eot = 1;
                if (eot) begin
                    m_state = 3;
                    m_done = 1;
                end else if (old == 2 && dack_n) begin
                    m_state = 1;
                end
            end
            if (reg_wr && reg_waddr == 8'hA2) m_tc = reg_wdata;
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && run) begin
            int exp_rd;
            chk(cur_req, "dreq", int'(dreq), int'(m_state == 1));
            chk(cur_req, "done", int'(done), int'(m_done));
            if (reg_raddr == 8'h21)      exp_rd = int'(m_cfg);
            else if (reg_raddr == 8'h22) exp_rd = int'(m_tc);
            else                         exp_rd = 0;
            chk(cur_req, "reg_rdata", int'(reg_rdata), exp_rd);
            if (!m_cfg[1] && m_state == 1 && m_val[m_ptr])
                chk(cur_req, "dout", int'(dout), int'(m_mem[m_ptr]));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 50000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic reg_write(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_dreq();
        for (int i = 0; i < 20; i++) begin
            if (dreq) break;
            @(negedge clk);
        end
    endtask

    // one word with acknowledge around it; optional end pulse on the strobe cycle
    task automatic single_word(bit wdir, logic [15:0] d, bit with_eot);
        wait_dreq();
        @(negedge clk);
        dack_n = 1'b0;
        if (wdir) wr_n = 1'b0; else rd_n = 1'b0;
        din = d;
        eot_ext = with_eot;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1; eot_ext = 1'b0; dack_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic burst(bit wdir, int n, logic [15:0] base);
        wait_dreq();
        @(negedge clk);
        dack_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (wdir) wr_n = 1'b0; else rd_n = 1'b0;
            din = base + 16'(i);
            @(negedge clk);
            wr_n = 1'b1; rd_n = 1'b1;
            @(negedge clk);
        end
        dack_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_eot();
        @(negedge clk);
        eot_ext = 1'b1;
        @(negedge clk);
        eot_ext = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run = 1'b1;
        @(negedge clk); #1;
        chk("R1", "dreq after reset", int'(dreq), 0);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "config after reset", int'(reg_rdata), 0);
        reg_raddr = 8'h22; #1;
        chk("R1", "count after reset", int'(reg_rdata), 0);

        cur_req = "R2";
        reg_write(8'hA2, 16'h0008);
        reg_write(8'hA1, 16'hFFF0);
        #1;
        chk("R2", "count readback", int'(reg_rdata), 16'h0008);
        reg_raddr = 8'h21; #1;
        chk("R2", "config keeps low 4 bits", int'(reg_rdata), 0);
        reg_raddr = 8'h30; #1;
        chk("R2", "unmapped read", int'(reg_rdata), 0);
        reg_raddr = 8'h21;

        // single-cycle writes, external end
        cur_req = "R6";
        reg_write(8'hA1, 16'h0003);
        #1;
        chk("R3", "dreq after arm", int'(dreq), 1);
        for (int i = 0; i < 5; i++) single_word(1'b1, 16'hA000 + 16'(i), 1'b0);
        cur_req = "R4";
        // read strobe in write direction: must not move a word
        single_word(1'b0, 16'h5555, 1'b0);
        cur_req = "R9";
        pulse_eot();
        @(negedge clk); #1;
        chk("R9", "done after external end", int'(done), 1);
        chk("R9", "dreq after external end", int'(dreq), 0);

        cur_req = "R10";
        @(negedge clk);
        dack_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            wr_n = 1'b0; din = 16'hDEAD;
            @(negedge clk);
            wr_n = 1'b1;
            @(negedge clk);
        end
        dack_n = 1'b1;

        // single-cycle reads back
        cur_req = "R5";
        reg_write(8'hA1, 16'h0001);
        #1;
        chk("R10", "word 0 untouched after done", int'(dout), 16'hA000);
        for (int i = 0; i < 5; i++) begin
            wait_dreq(); #1;
            chk("R5", "read word", int'(dout), 16'hA000 + i);
            single_word(1'b0, 16'h0, 1'b0);
        end
        pulse_eot();

        // burst writes with internal end at 16 bytes
        cur_req = "R7";
        reg_write(8'hA2, 16'd16);
        reg_write(8'hA1, 16'h000F);
        burst(1'b1, 4, 16'hB000);
        cur_req = "R8";
        pulse_eot();
        @(negedge clk); #1;
        chk("R8", "external end ignored in counter mode", int'(done), 0);
        burst(1'b1, 4, 16'hB004);
        #1;
        chk("R8", "done at count match", int'(done), 1);
        chk("R8", "dreq low at count match", int'(dreq), 0);

        // burst reads back
        cur_req = "R7";
        reg_write(8'hA1, 16'h000D);
        burst(1'b0, 4, 16'h0);
        burst(1'b0, 4, 16'h0);
        #1;
        chk("R7", "done after burst read", int'(done), 1);

        // counter match ignored in external mode
        cur_req = "R9";
        reg_write(8'hA2, 16'd2);
        reg_write(8'hA1, 16'h0003);
        single_word(1'b1, 16'hC000, 1'b0);
        single_word(1'b1, 16'hC001, 1'b0);
        #1;
        chk("R9", "count match ignored", int'(done), 0);

        // strobe together with external end
        cur_req = "R11";
        reg_write(8'hA1, 16'h0003);
        single_word(1'b1, 16'h7E57, 1'b1);
        #1;
        chk("R11", "done after end with strobe", int'(done), 1);
        reg_write(8'hA1, 16'h0001);
        #1;
        chk("R11", "word written with end", int'(dout), 16'h7E57);

        cur_req = "R3";
        reg_write(8'hA1, 16'h0000);
        #1;
        chk("R3", "dreq after disarm", int'(dreq), 0);
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule